// File: doc/BRIEF.md
# Power-of-Two Signed Divide and Remainder Unit

This block divides an N-bit operand by a run-time power of two, 2^k, and returns either the quotient or the remainder. No iterative divider is involved. The quotient comes from a right shift and the remainder from a low-bit mask. A one-bit sign-dependent correction then turns the flooring result into the truncating one.

Three control inputs pick the behaviour. The first chooses quotient or remainder. The second chooses rounding toward zero or toward minus infinity. The third says whether the operand is two's-complement signed. A zero-divisor input forces the result to zero. An optional output register stage carries a valid bit alongside the data.

Top module: `pow2_divmod`

## Requirements
- R1: With op_floor=1 and op_mod=0, y_out is floor(A / 2^k): an arithmetic right shift by k_in when a_signed=1 and a logical right shift when a_signed=0.
- R2: With op_floor=0, op_mod=0 and a_signed=1, y_out is A / 2^k rounded toward zero. For a negative A whose low k bits are nonzero, this is the flooring quotient plus one.
- R3: With op_floor=1 and op_mod=1, y_out holds the low k bits of A and every bit above them is zero.
- R4: With op_floor=0, op_mod=1 and a_signed=1, the low k bits of y_out equal those of A. The bits above them are copies of A's sign bit when those low bits are nonzero, and zero otherwise.
- R5: With a_signed=0, both rounding modes give the same quotient and the same remainder, treating A as unsigned.
- R6: With k_in=0 (divisor 1), the quotient equals A and the remainder is 0 in every mode.
- R7: With div_zero=1, y_out is all zeros whatever the other inputs are.
- R8: With REG_OUT=1, y_out and valid_out show the result for the inputs from one clock earlier. An active-low asynchronous reset clears both to 0. With REG_OUT=0, the path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Marks the current inputs as meaningful |
| a_in | input | N | Dividend |
| k_in | input | $clog2(N) | Exponent k of the divisor 2^k |
| a_signed | input | 1 | 1: dividend is two's complement |
| op_mod | input | 1 | 0: quotient, 1: remainder |
| op_floor | input | 1 | 0: round toward zero, 1: round toward minus infinity |
| div_zero | input | 1 | 1: divisor is zero, result forced to 0 |
| valid_out | output | 1 | valid_in aligned with y_out |
| y_out | output | N | Quotient or remainder |

## Verification
The assertions assume the control inputs are known 0/1 values on every clock edge after reset. They also assume k_in never exceeds N-1, which the exponent width guarantees when N is a power of two. The bench uses N=8. It drives every control and operand value from a single process on the falling edge, so every combination it applies satisfies these assumptions. The assertions only check properties that hold for every operand, such as the sign of a negative flooring quotient and the zero upper bits of a flooring remainder. Exact values are left to the bench's arithmetic model.

// File: rtl/pow2_divmod.sv
module pow2_divmod #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int KW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_in,
  input  logic [N-1:0]  a_in,
  input  logic [KW-1:0] k_in,
  input  logic          a_signed,
  input  logic          op_mod,
  input  logic          op_floor,
  input  logic          div_zero,
  output logic          valid_out,
  output logic [N-1:0]  y_out
);

  logic signed [N-1:0] a_s;
  logic [N-1:0] ashr, lshr, low_mask, low_bits, q_floor, q_trunc, r_trunc, y_next;
  logic neg_a, low_nz, bump;

  assign a_s      = a_in;
  assign ashr     = a_s >>> k_in;
  assign lshr     = a_in >> k_in;
  assign low_mask = ~({N{1'b1}} << k_in);
  assign low_bits = a_in & low_mask;
  assign low_nz   = |low_bits;
  assign neg_a    = a_signed & a_in[N-1];
  assign bump     = neg_a & low_nz;

  assign q_floor = a_signed ? ashr : lshr;
  assign q_trunc = q_floor + {{(N-1){1'b0}}, bump};
  assign r_trunc = bump ? (low_bits | ~low_mask) : low_bits;

  always_comb begin
    if (div_zero)      y_next = '0;
    else if (op_mod)   y_next = op_floor ? low_bits : r_trunc;
    else               y_next = op_floor ? q_floor  : q_trunc;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        y_out     <= '0;
        valid_out <= 1'b0;
      end else begin
        y_out     <= y_next;
        valid_out <= valid_in;
      end
    end
  end else begin : g_comb
    assign y_out     = y_next;
    assign valid_out = valid_in;
  end

endmodule

module pow2_divmod_chk #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int KW     = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_in,
  input logic [N-1:0]  a_in,
  input logic [KW-1:0] k_in,
  input logic          a_signed,
  input logic          op_mod,
  input logic          op_floor,
  input logic          div_zero,
  input logic          valid_out,
  input logic [N-1:0]  y_out
);

  logic          live, p_valid, p_sg, p_mod, p_fl, p_dz;
  logic [N-1:0]  p_a;
  logic [KW-1:0] p_k;
  logic [N-1:0]  p_hi;

  if (REG_OUT) begin : g_track
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live <= 1'b0; p_valid <= 1'b0; p_sg <= 1'b0; p_mod <= 1'b0;
        p_fl <= 1'b0; p_dz <= 1'b0; p_a <= '0; p_k <= '0;
      end else begin
        live <= 1'b1; p_valid <= valid_in; p_sg <= a_signed; p_mod <= op_mod;
        p_fl <= op_floor; p_dz <= div_zero; p_a <= a_in; p_k <= k_in;
      end
    end
  end else begin : g_track
    assign live = 1'b1;   assign p_valid = valid_in; assign p_sg = a_signed;
    assign p_mod = op_mod; assign p_fl = op_floor;   assign p_dz = div_zero;
    assign p_a = a_in;     assign p_k = k_in;
  end

  assign p_hi = {N{1'b1}} << p_k;

  assert_valid_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> valid_out == p_valid);

  assert_zero_divisor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && p_dz) |-> y_out == '0);

  assert_unit_quot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !p_dz && !p_mod && p_k == '0) |-> y_out == p_a);

  assert_unit_rem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !p_dz && p_mod && p_k == '0) |-> y_out == '0);

  assert_floor_rem_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !p_dz && p_mod && p_fl) |-> (y_out & p_hi) == '0);

  assert_trunc_rem_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !p_dz && p_mod && !p_fl && p_sg && p_a[N-1]) |-> (y_out == '0 || y_out[N-1]));

  assert_floor_quot_neg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !p_dz && !p_mod && p_fl && p_sg && p_a[N-1]) |-> y_out[N-1]);

endmodule

bind pow2_divmod pow2_divmod_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .a_in(a_in), .k_in(k_in),
  .a_signed(a_signed), .op_mod(op_mod), .op_floor(op_floor), .div_zero(div_zero),
  .valid_out(valid_out), .y_out(y_out)
);

// File: tb/pow2_divmod_bench.sv
`timescale 1ns/1ps
module pow2_divmod_bench;
  localparam int N  = 8;
  localparam int KW = 3;

  logic clk = 1'b0, rst_n = 1'b0, valid_in = 1'b0;
  logic [N-1:0] a_in = '0;
  logic [KW-1:0] k_in = '0;
  logic a_signed = 1'b0, op_mod = 1'b0, op_floor = 1'b0, div_zero = 1'b0;
  logic valid_out;
  logic [N-1:0] y_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pow2_divmod #(.N(N), .REG_OUT(1'b1)) u_pow2_divmod (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .a_in(a_in), .k_in(k_in),
    .a_signed(a_signed), .op_mod(op_mod), .op_floor(op_floor), .div_zero(div_zero),
    .valid_out(valid_out), .y_out(y_out)
  );

  function automatic logic [N-1:0] model(logic [N-1:0] a, int k, bit sg, bit md, bit fl);
    int av, d, q, r;
    av = sg ? int'($signed(a)) : int'(a);
    d  = 1 << k;
    q  = av / d;
    r  = av % d;
    if (fl && r != 0 && av < 0) begin
      q = q - 1;
      r = av - q * d;
    end
    return md ? r[N-1:0] : q[N-1:0];
  endfunction

  function automatic string tag(int k, bit sg, bit md, bit fl);
    if (k == 0)  return "R6";
    if (!sg)     return "R5";
    if (md)      return fl ? "R3" : "R4";
    return fl ? "R1" : "R2";
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5.0);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset y_out", y_out, '0);
    check("R8 reset valid_out", {7'd0, valid_out}, 8'd0);
    rst_n = 1'b1;

    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < N; k++) begin
        for (int a = 0; a < 256; a++) begin
          a_in = a[N-1:0]; k_in = k[KW-1:0];
          a_signed = m[0]; op_mod = m[1]; op_floor = m[2];
          div_zero = 1'b0; valid_in = a[0];
          @(negedge clk);
          check(tag(k, m[0], m[1], m[2]), y_out, model(a[N-1:0], k, m[0], m[1], m[2]));
          if (a % 64 == 0)
            check("R8 valid", {7'd0, valid_out}, {7'd0, a[0]});
        end
      end
    end

    for (int i = 0; i < 64; i++) begin
      a_in = 8'(i * 37 + 5); k_in = 3'(i); a_signed = i[3];
      op_mod = i[4]; op_floor = i[5]; div_zero = 1'b1; valid_in = 1'b1;
      @(negedge clk);
      check("R7 zero divisor", y_out, '0);
    end

    div_zero = 1'b0; valid_in = 1'b0;
    @(negedge clk);
    check("R8 valid drop", {7'd0, valid_out}, 8'd0);
    finish_run();
  end
endmodule